// File: doc/BRIEF.md
# Serial Dot-Matrix Display Write Sequencer

This block sits on the host side of a chain of serially loaded LED dot-matrix driver chips. It turns short commands into the pin waveforms those chips expect: a shift clock, an active-low chip enable, a register-select line, serial data, and an active-low chip reset. A command either sends a whole dot frame, which is read bit by bit from an external frame buffer through an address/data port, or sends one 8-bit control byte. Commands arrive over a valid/ready handshake, and a one-cycle done pulse marks the end of each one.

Every pin phase lasts `PHASE_CYC` system clocks, so the minimum setup, hold and pulse-width times are met by choosing that parameter. With a 100 MHz system clock, a value of 8 gives 80 ns phases. After reset the block pulses the chip reset, then clears the dot memory of the chain by sending an all-zero frame. It then wakes the chips with a control byte that selects the first control word, sets the wake bit and carries the `BOOT_LEVEL` brightness. Only after that does it accept commands.

The block keeps track of whether the chips are in broadcast (simultaneous) control mode. It uses this to size each control write: the byte goes out once per chip in the chain, or only once when broadcast mode is on.

Top module: `dispwr_seq`

## Requirements
- R1: While the system reset is asserted and for the first `PHASE_CYC` cycles after it is released, `disp_rst_n` is low, `disp_ce_n` is high, `disp_clk` is low and `cmd_ready` is low.
- R2: After the reset pulse, the block sends a dot frame of 160·`N_CHIPS` zero bits with `disp_rs` low. It then sends the control byte {0, 1, `BOOT_LEVEL`[5:0]} with `disp_rs` high, once per chip, most significant bit first. It then raises `cmd_ready` without any `cmd_done` pulse.
- R3: `disp_rs` takes its value (0 for a dot frame, 1 for a control byte) one phase before `disp_ce_n` falls. It does not change while `disp_ce_n` is low, and it holds its value until the next transfer starts.
- R4: Each transfer has one phase with RS set and CE high, then one phase with CE low and the clock low before the first rising clock edge. After the last clock-high phase come one phase with CE low and the clock low, then one phase with CE high and the clock low.
- R5: `disp_clk` alternates a low phase and a high phase of exactly `PHASE_CYC` cycles each, and it is high only while `disp_ce_n` is low.
- R6: `disp_din` changes only when a clock-low phase starts inside a transfer, so it is stable across each rising clock edge and for the whole high phase.
- R7: A dot-frame command (`cmd_ctrl`=0) produces exactly 160·`N_CHIPS` rising clock edges. The k-th edge, counting from 0, carries `fb_bit` read at `fb_addr`=k, so buffer address 0 (the left-most column) goes out first.
- R8: A control command (`cmd_ctrl`=1) sends `cmd_word` most significant bit first. The byte goes out 8·`N_CHIPS` bits long (repeated per chip) in serial mode, or as 8 bits in broadcast mode. Broadcast mode turns on or off to the value of bit 0 when a control write with bit 7 set completes. Reset leaves it off.
- R9: `cmd_ready` is high only when the block is idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_done` is a one-cycle pulse in the first idle cycle after a host command's final CE-high phase, and a command may be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_ctrl | input | 1 | 0: send dot frame, 1: send control byte |
| cmd_word | input | 8 | Control byte for a control command |
| cmd_done | output | 1 | One-cycle pulse at command completion |
| fb_addr | output | $clog2(160·N_CHIPS) | Frame buffer bit address |
| fb_bit | input | 1 | Frame buffer bit at `fb_addr` (combinational read) |
| disp_rst_n | output | 1 | Active-low reset to the display chips |
| disp_rs | output | 1 | Register select (0 dot, 1 control) |
| disp_ce_n | output | 1 | Active-low chip enable |
| disp_clk | output | 1 | Serial shift clock |
| disp_din | output | 1 | Serial data |

## Verification
A bad phase counter or state register shows up at the pins within one phase. A CE or clock edge lands on the wrong cycle, and because the reference model predicts every pin on every cycle, the bench flags it at that very cycle. A wrong bit counter or a wrong broadcast-mode flag shows up as a wrong number of rising edges inside one CE-low window. This is reported when CE rises at the end of that transfer, and it also shows up cycle by cycle as a CE edge the model does not expect. A wrong data selection shows up on `disp_din` in the clock-low phase where that bit is first driven.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;

    typedef enum logic [2:0] {
        ST_RSTP = 3'd0,   // chip reset pulse
        ST_RSEL = 3'd1,   // register select set, CE high
        ST_CEDN = 3'd2,   // CE low, clock low, before first edge
        ST_CLO  = 3'd3,   // clock low, data driven
        ST_CHI  = 3'd4,   // clock high
        ST_TAIL = 3'd5,   // CE low, clock low after last edge
        ST_CEUP = 3'd6,   // CE high, clock low: commit
        ST_IDLE = 3'd7
    } seq_st_e;

    typedef enum logic [1:0] {
        SRC_BOOT_DOT = 2'd0,
        SRC_BOOT_CTL = 2'd1,
        SRC_USER     = 2'd2
    } job_src_e;

endpackage

// File: rtl/dispwr_phase_tmr.sv
module dispwr_phase_tmr #(
    parameter int PHASE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int PW = $clog2(PHASE_CYC + 1);
    localparam logic [PW-1:0] LAST_V = PW'(PHASE_CYC - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign last = run && (cnt_q == LAST_V);

    always_comb begin
        if (!run || last) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last) |-> (cnt_q == '0));
endmodule

// File: rtl/dispwr_bitsel.sv
module dispwr_bitsel (
    input  logic       sel_ctrl,
    input  logic       zero_fill,
    input  logic [7:0] word,
    input  logic [2:0] idx,
    input  logic       fb_bit,
    output logic       bit_o
);
    logic ctrl_bit;

    // control bytes go out most significant bit first
    assign ctrl_bit = word[3'd7 - idx];

    always_comb begin
        if (sel_ctrl)       bit_o = ctrl_bit;
        else if (zero_fill) bit_o = 1'b0;
        else                bit_o = fb_bit;
    end
endmodule

// File: rtl/dispwr_seq.sv
module dispwr_seq
    import dispwr_pkg::*;
#(
    parameter int          N_CHIPS    = 2,
    parameter int          CHIP_DOTS  = 160,
    parameter int          PHASE_CYC  = 8,
    parameter logic [5:0]  BOOT_LEVEL = 6'h2D,
    localparam int         DOT_BITS   = CHIP_DOTS * N_CHIPS,
    localparam int         AW         = $clog2(DOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_ctrl,
    input  logic [7:0]    cmd_word,
    output logic          cmd_done,
    output logic [AW-1:0] fb_addr,
    input  logic          fb_bit,
    output logic          disp_rst_n,
    output logic          disp_rs,
    output logic          disp_ce_n,
    output logic          disp_clk,
    output logic          disp_din
);
    localparam int CW = $clog2(DOT_BITS + 1);
    localparam logic [CW-1:0] NB_DOT = CW'(DOT_BITS);
    localparam logic [CW-1:0] NB_ALL = CW'(8 * N_CHIPS);
    localparam logic [CW-1:0] NB_ONE = CW'(8);
    localparam logic [7:0]    BOOT_WORD = {2'b01, BOOT_LEVEL};

    typedef struct packed {
        seq_st_e        st;
        job_src_e       src;
        logic           ctrl;
        logic [7:0]     word;
        logic [CW-1:0]  nbits;
        logic [CW-1:0]  bcnt;
        logic           simul;
        logic           o_rstn;
        logic           o_rs;
        logic           o_ce_n;
        logic           o_clk;
        logic           o_din;
        logic           o_done;
    } regs_t;

    regs_t d, q;
    logic  ph_last;
    logic  next_bit;

    dispwr_phase_tmr #(.PHASE_CYC(PHASE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .last  (ph_last)
    );

    dispwr_bitsel u_bitsel (
        .sel_ctrl  (q.ctrl),
        .zero_fill (q.src == SRC_BOOT_DOT),
        .word      (q.word),
        .idx       (q.bcnt[2:0]),
        .fb_bit    (fb_bit),
        .bit_o     (next_bit)
    );

    assign fb_addr    = AW'(q.bcnt);
    assign cmd_ready  = (q.st == ST_IDLE);
    assign cmd_done   = q.o_done;
    assign disp_rst_n = q.o_rstn;
    assign disp_rs    = q.o_rs;
    assign disp_ce_n  = q.o_ce_n;
    assign disp_clk   = q.o_clk;
    assign disp_din   = q.o_din;

    always_comb begin
        d        = q;
        d.o_done = 1'b0;
        unique case (q.st)
            ST_RSTP: if (ph_last) begin
                d.st    = ST_RSEL;
                d.src   = SRC_BOOT_DOT;
                d.ctrl  = 1'b0;
                d.nbits = NB_DOT;
                d.bcnt  = '0;
            end
            ST_RSEL: if (ph_last) d.st = ST_CEDN;
            ST_CEDN: if (ph_last) d.st = ST_CLO;
            ST_CLO: if (ph_last) begin
                d.st   = ST_CHI;
                d.bcnt = q.bcnt + 1'b1;
            end
            ST_CHI: if (ph_last) begin
                d.st = (q.bcnt == q.nbits) ? ST_TAIL : ST_CLO;
            end
            ST_TAIL: if (ph_last) d.st = ST_CEUP;
            ST_CEUP: if (ph_last) begin
                if (q.src == SRC_BOOT_DOT) begin
                    d.st    = ST_RSEL;
                    d.src   = SRC_BOOT_CTL;
                    d.ctrl  = 1'b1;
                    d.word  = BOOT_WORD;
                    d.nbits = q.simul ? NB_ONE : NB_ALL;
                    d.bcnt  = '0;
                end else begin
                    d.st = ST_IDLE;
                    if (q.ctrl && q.word[7]) d.simul = q.word[0];
                    d.o_done = (q.src == SRC_USER);
                end
            end
            ST_IDLE: if (cmd_valid) begin
                d.st    = ST_RSEL;
                d.src   = SRC_USER;
                d.ctrl  = cmd_ctrl;
                d.word  = cmd_word;
                d.nbits = cmd_ctrl ? (q.simul ? NB_ONE : NB_ALL) : NB_DOT;
                d.bcnt  = '0;
            end
            default: d.st = ST_IDLE;
        endcase

        // registered pin values follow the next state
        d.o_rstn = (d.st != ST_RSTP);
        d.o_ce_n = !((d.st == ST_CEDN) || (d.st == ST_CLO) ||
                     (d.st == ST_CHI)  || (d.st == ST_TAIL));
        d.o_clk  = (d.st == ST_CHI);
        if (d.st == ST_RSEL) d.o_rs = d.ctrl;
        if ((d.st == ST_CLO) && (q.st != ST_CLO)) d.o_din = next_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_RSTP;
            q.src    <= SRC_BOOT_DOT;
            q.ctrl   <= 1'b0;
            q.word   <= '0;
            q.nbits  <= NB_DOT;
            q.bcnt   <= '0;
            q.simul  <= 1'b0;
            q.o_rstn <= 1'b0;
            q.o_rs   <= 1'b0;
            q.o_ce_n <= 1'b1;
            q.o_clk  <= 1'b0;
            q.o_din  <= 1'b0;
            q.o_done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R1
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> (disp_ce_n && !disp_clk && !cmd_ready));

    // R3
    rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ce_n |-> $stable(disp_rs));

    // R4
    ce_edge_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(disp_ce_n) || $rose(disp_ce_n)) |-> !disp_clk);

    // R5
    clk_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_clk |-> !disp_ce_n);

    // R6
    din_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_clk |-> $stable(disp_din));

    // R9
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cmd_ready && disp_ce_n && !disp_clk));

    // R9
    ready_ce_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (disp_ce_n && disp_rst_n));
endmodule

// File: tb/dispwr_seq_tb.sv
module dispwr_seq_tb;
    localparam int         NC   = 2;
    localparam int         PH   = 3;
    localparam int         DOTS = 160 * NC;
    localparam int         AW   = $clog2(DOTS);
    localparam logic [5:0] BL   = 6'h2D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_ctrl = 1'b0;
    logic [7:0]    cmd_word = '0;
    logic          cmd_done;
    logic [AW-1:0] fb_addr;
    logic          fb_bit;
    logic          disp_rst_n, disp_rs, disp_ce_n, disp_clk, disp_din;
    logic [DOTS-1:0] fb_mem;

    assign fb_bit = fb_mem[fb_addr];

    dispwr_seq #(.N_CHIPS(NC), .PHASE_CYC(PH), .BOOT_LEVEL(BL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ctrl(cmd_ctrl),
        .cmd_word(cmd_word), .cmd_done(cmd_done),
        .fb_addr(fb_addr), .fb_bit(fb_bit),
        .disp_rst_n(disp_rst_n), .disp_rs(disp_rs), .disp_ce_n(disp_ce_n),
        .disp_clk(disp_clk), .disp_din(disp_din)
    );

    int  errs = 0;
    int  checks = 0;
    bit  finished = 0;

    // tuple: {boot, ready, done, din, clk, ce_n, rs, rstn}
    logic [7:0] expq[$];
    int         cntq[$];
    bit         kindq[$];
    logic       m_din = 1'b0;
    logic       m_rs = 1'b0;
    logic       m_simul = 1'b0;
    bit         model_on = 0;
    bit         model_idle = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_n(int n, logic [7:0] v);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    task automatic push_xfer(bit ctrl, logic [7:0] w, bit zero, bit user);
        int   nb;
        logic b;
        logic bt;
        bt = !user;
        nb = ctrl ? (m_simul ? 8 : 8 * NC) : DOTS;
        push_n(PH, {bt, 2'b00, m_din, 1'b0, 1'b1, ctrl, 1'b1});
        push_n(PH, {bt, 2'b00, m_din, 1'b0, 1'b0, ctrl, 1'b1});
        for (int k = 0; k < nb; k++) begin
            b = ctrl ? w[7 - (k % 8)] : (zero ? 1'b0 : fb_mem[k]);
            m_din = b;
            push_n(PH, {bt, 2'b00, b, 1'b0, 1'b0, ctrl, 1'b1});
            push_n(PH, {bt, 2'b00, b, 1'b1, 1'b0, ctrl, 1'b1});
        end
        push_n(PH, {bt, 2'b00, m_din, 1'b0, 1'b0, ctrl, 1'b1});
        push_n(PH, {bt, 2'b00, m_din, 1'b0, 1'b1, ctrl, 1'b1});
        m_rs = ctrl;
        cntq.push_back(nb);
        kindq.push_back(ctrl);
        if (user) push_n(1, {1'b0, 2'b11, m_din, 1'b0, 1'b1, ctrl, 1'b1});
        if (ctrl && w[7]) m_simul = w[0];
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        logic [7:0] e;
        if (model_on && !finished) begin
            if (expq.size() > 0) e = expq.pop_front();
            else e = {1'b0, 2'b10, m_din, 1'b0, 1'b1, m_rs, 1'b1};
            chk(disp_rst_n == e[0], "R1", "disp_rst_n", disp_rst_n, e[0]);
            chk(disp_rs    == e[1], "R3", "disp_rs",    disp_rs,    e[1]);
            chk(disp_ce_n  == e[2], "R4", "disp_ce_n",  disp_ce_n,  e[2]);
            chk(disp_clk   == e[3], "R5", "disp_clk",   disp_clk,   e[3]);
            chk(disp_din   == e[4], e[7] ? "R2" : "R6", "disp_din", disp_din, e[4]);
            chk(cmd_done   == e[5], "R9", "cmd_done",   cmd_done,   e[5]);
            chk(cmd_ready  == e[6], "R9", "cmd_ready",  cmd_ready,  e[6]);
            model_idle = e[6];
        end
    end

    always @(posedge clk) begin
        if (model_on && model_idle && cmd_valid)
            push_xfer(cmd_ctrl, cmd_word, 1'b0, 1'b1);
    end

    // rising clock edges per CE-low window
    logic prev_clk = 1'b0;
    logic prev_ce  = 1'b1;
    int   rises = 0;
    always @(negedge clk) begin
        int  ex;
        bit  kd;
        if (model_on && !finished) begin
            if (!disp_ce_n && disp_clk && !prev_clk) rises++;
            if (disp_ce_n && !prev_ce) begin
                if (cntq.size() > 0) begin
                    ex = cntq.pop_front();
                    kd = kindq.pop_front();
                    chk(rises == ex, kd ? "R8" : "R7", "clock edges per transfer", rises, ex);
                end else begin
                    chk(1'b0, "R9", "unexpected transfer end", 1, 0);
                end
                rises = 0;
            end
        end
        prev_clk = disp_clk;
        prev_ce  = disp_ce_n;
    end

    task automatic send(bit c, logic [7:0] w);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_ctrl  = c;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        for (int i = 0; i < DOTS; i++) fb_mem[i] = (((i * 5) + (i / 7)) % 3) == 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset pulse, then R2 boot frame and wake byte
        push_n(PH, {1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
        push_xfer(1'b0, 8'h00, 1'b1, 1'b0);
        push_xfer(1'b1, {2'b01, BL}, 1'b0, 1'b0);
        rst_n    = 1'b1;
        model_on = 1;
        @(negedge clk);
        // R1 explicit reset-state check
        chk(!disp_rst_n && disp_ce_n && !disp_clk && !cmd_ready, "R1",
            "reset pins", {disp_rst_n, disp_ce_n, disp_clk, cmd_ready}, 4'b0100);

        wait_idle();
        // R2: both boot transfers consumed, no done pulse seen
        chk(cntq.size() == 0, "R2", "boot transfers pending", cntq.size(), 0);

        send(1'b0, 8'h00);          // R7 dot frame, pattern A
        send(1'b1, 8'h4D);          // R8 word 0, serial: 16 bits
        send(1'b1, 8'h81);          // R8 enables broadcast (still 16 bits)
        send(1'b1, 8'h35);          // R8 broadcast: 8 bits
        send(1'b1, 8'h80);          // R8 disables broadcast: 8 bits
        send(1'b1, 8'h12);          // R8 serial again: 16 bits
        wait_idle();
        repeat (7) @(negedge clk);  // R9 idle with no request stays quiet

        for (int i = 0; i < DOTS; i++) fb_mem[i] = ((i % 11) < 4) ^ (i >= DOTS / 2);
        send(1'b0, 8'h00);          // R7 pattern B, back-to-back with next
        send(1'b1, 8'hC3);          // R8 bit7 set, bit0 set
        send(1'b1, 8'hA5);          // R8 broadcast byte
        wait_idle();
        repeat (4) @(negedge clk);

        chk(expq.size() == 0, "R9", "model tuples left", expq.size(), 0);
        chk(cntq.size() == 0, "R9", "transfers left", cntq.size(), 0);
        if (!finished) begin
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule